// File: doc/BRIEF.md
# Programmable Interrupt Priority Router

The router takes sixteen level-sensitive, active-high peripheral interrupt lines and steers each one onto one of twelve request lines toward a processor core. Request line 0 carries the most urgent level and line 11 the least urgent. Each source owns a 4-bit level field. A value from 0 to 11 picks the request line the source drives. A value of 12 or above silences the source. Any number of sources may share one line, and that line is then the OR of its routed, active sources.

Software programs the level fields through a small word-addressed register bus. Four priority words each pack four fields. It can also read one status word per request line, which shows the sources currently driving that line. The status words let an interrupt handler find which peripheral raised a shared line. Source inputs are resynchronised to the block clock by a two-stage synchroniser. Request outputs and status words are combinational functions of the synchronised sources and the stored fields.

Top module: `irq_prio_router`

## Requirements
- R1: After reset the priority words at bus addresses 0, 1, 2 and 3 read 0x3210, 0x7654, 0xBA98 and 0x0BBB, and every request output is 0.
- R2: The level field of source i lives in priority word i/4, at bits 4*(i%4)+3 down to 4*(i%4). The lowest-numbered source of a word sits in bits 3:0.
- R3: A source whose field holds a value v below 12 drives request output v high while it is active, and drives no other request output.
- R4: A source whose field holds 12, 13, 14 or 15 drives no request output, and its bit is 0 in every status word.
- R5: When several active sources are routed to the same level, that request output is their OR. It stays high until the last of them goes inactive.
- R6: The status word of request line k reads at bus address 4+k. Its bit i is 1 exactly when source i is active (after synchronisation) and its field equals k.
- R7: A write to a status address (4 to 15) or to an unmapped address (16 to 31) changes no stored state. A read of an unmapped address returns 0.
- R8: A change on a source input shows at the request outputs after exactly two rising clock edges, and not after one.
- R9: A bus write to priority word 0 to 3 is stored at the next rising edge. From then on the word reads back as written and the new fields govern routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 16 | Peripheral interrupt lines, active high, level-sensitive |
| req_o | output | 12 | Request lines toward the core, bit 0 most urgent |
| bus_addr | input | 5 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The reset routing is tried with single sources taken from each priority word. This shows that each field is decoded from the right bit position, including the top field of the last word. Reprogrammed words then place several sources on one level, which tells the OR of shared lines apart from a priority pick. Masked values 12 to 15 are tried to tell masking apart from routing to the nearest valid line. A step on the sources is sampled one edge and then two edges later to pin the synchroniser depth. Writes to status and unmapped addresses are followed by read-back of all priority words. Finally, pseudo-random field words and source patterns are compared against a model on all request lines and on sampled status words.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Width of one per-source level field.
  localparam int unsigned LVL_W  = 4;
  // Width of one bus word.
  localparam int unsigned WORD_W = 16;

  // Region of the register space that a bus address falls into.
  typedef enum logic [1:0] {
    REG_PRIO = 2'd0,
    REG_STAT = 2'd1,
    REG_NONE = 2'd2
  } region_e;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = din;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '0;
        end else begin
          stg_q[s] <= stg_d[s];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int unsigned N_WORD = 4,
  parameter int unsigned WORD_W = 16,
  parameter logic [N_WORD*WORD_W-1:0] RESET_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_WORD-1:0]        word_we,
  input  logic [WORD_W-1:0]        wdata,
  output logic [N_WORD*WORD_W-1:0] levels
);

  logic [N_WORD*WORD_W-1:0] lvl_q;
  logic [N_WORD*WORD_W-1:0] lvl_d;
  logic                     lvl_en;

  // Next state: each selected word takes the write data.
  always_comb begin
    lvl_d = lvl_q;
    for (int w = 0; w < N_WORD; w++) begin
      if (word_we[w]) begin
        lvl_d[w*WORD_W +: WORD_W] = wdata;
      end
    end
  end

  assign lvl_en = |word_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RESET_VAL;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  assign levels = lvl_q;

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned N_REQ = 12,
  parameter int unsigned LVL_W = 4
) (
  input  logic [N_SRC-1:0]       src,
  input  logic [N_SRC*LVL_W-1:0] levels,
  output logic [N_REQ*N_SRC-1:0] hit,
  output logic [N_REQ-1:0]       req
);

  genvar k, i;
  generate
    for (k = 0; k < N_REQ; k++) begin : g_line
      for (i = 0; i < N_SRC; i++) begin : g_src
        // A level outside 0..N_REQ-1 never matches, so it masks the source.
        assign hit[k*N_SRC + i] = src[i] &&
                                  (levels[i*LVL_W +: LVL_W] == LVL_W'(k));
      end
      assign req[k] = |hit[k*N_SRC +: N_SRC];
    end
  endgenerate

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_router_pkg::*;
#(
  parameter int unsigned N_WORD = 4,
  parameter int unsigned N_REQ  = 12,
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [N_WORD*WORD_W-1:0] levels,
  input  logic [N_REQ*N_SRC-1:0]   hit,
  output logic [N_WORD-1:0]        word_we,
  output logic [WORD_W-1:0]        rdata
);

  localparam int unsigned STAT_BASE = N_WORD;
  localparam int unsigned STAT_END  = N_WORD + N_REQ;

  region_e region;

  always_comb begin
    if (32'(bus_addr) < STAT_BASE) begin
      region = REG_PRIO;
    end else if (32'(bus_addr) < STAT_END) begin
      region = REG_STAT;
    end else begin
      region = REG_NONE;
    end
  end

  // Only the priority region accepts writes.
  always_comb begin
    word_we = '0;
    for (int w = 0; w < N_WORD; w++) begin
      if (bus_wr && (region == REG_PRIO) && (bus_addr == ADDR_W'(w))) begin
        word_we[w] = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (region)
      REG_PRIO: begin
        for (int w = 0; w < N_WORD; w++) begin
          if (bus_addr == ADDR_W'(w)) begin
            rdata = levels[w*WORD_W +: WORD_W];
          end
        end
      end
      REG_STAT: begin
        for (int k = 0; k < N_REQ; k++) begin
          if (bus_addr == ADDR_W'(STAT_BASE + k)) begin
            rdata = WORD_W'(hit[k*N_SRC +: N_SRC]);
          end
        end
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC     = 16,
  parameter int unsigned N_REQ     = 12,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter logic [N_SRC*LVL_W-1:0] RESET_LEVELS = 64'h0BBB_BA98_7654_3210
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    src_i,
  output logic [N_REQ-1:0]    req_o,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata
);

  localparam int unsigned FIELDS_PER_WORD = WORD_W / LVL_W;
  localparam int unsigned N_WORD          = N_SRC / FIELDS_PER_WORD;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_d;
  logic       rst_core_n;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  logic [N_SRC-1:0]         src_sync;
  logic [N_WORD*WORD_W-1:0] lvl_flat;
  logic [N_REQ*N_SRC-1:0]   hit_flat;
  logic [N_WORD-1:0]        word_we;

  irq_src_sync #(
    .W      (N_SRC),
    .STAGES (SYNC_DEPTH)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (src_i),
    .dout  (src_sync)
  );

  irq_prio_bank #(
    .N_WORD    (N_WORD),
    .WORD_W    (WORD_W),
    .RESET_VAL (RESET_LEVELS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .word_we (word_we),
    .wdata   (bus_wdata),
    .levels  (lvl_flat)
  );

  irq_route_matrix #(
    .N_SRC (N_SRC),
    .N_REQ (N_REQ),
    .LVL_W (LVL_W)
  ) u_matrix (
    .src    (src_sync),
    .levels (lvl_flat),
    .hit    (hit_flat),
    .req    (req_o)
  );

  irq_bus_port #(
    .N_WORD (N_WORD),
    .N_REQ  (N_REQ),
    .N_SRC  (N_SRC),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_port (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .levels   (lvl_flat),
    .hit      (hit_flat),
    .word_we  (word_we),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned N_REQ  = 12,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_WORD = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SRC-1:0]         src_i,
  input logic [N_REQ-1:0]         req_o,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_wr,
  input logic [WORD_W-1:0]        bus_wdata,
  input logic [WORD_W-1:0]        bus_rdata,
  input logic [N_WORD*WORD_W-1:0] levels,
  input logic [N_REQ*N_SRC-1:0]   hit
);

  logic [N_SRC-1:0][N_REQ-1:0] col;

  genvar i, k;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_col
      for (k = 0; k < N_REQ; k++) begin : g_row
        assign col[i][k] = hit[k*N_SRC + i];
      end

      // R4: a masking level keeps the source off every line.
      a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (levels[i*LVL_W +: LVL_W] >= LVL_W'(N_REQ)) |-> (col[i] == '0));

      // R3: a source lands on at most one line.
      a_r3_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col[i]));
    end

    for (k = 0; k < N_REQ; k++) begin : g_line
      // R6: the status word of a line agrees with its request output.
      a_r6_status_matches_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_o[k] == (|hit[k*N_SRC +: N_SRC]));
    end
  endgenerate

  // R8: with sources quiet two edges ago, no request can be high.
  a_r8_quiet_sources: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_i, 2) == '0) |-> (req_o == '0));

  // R5: lines raised never outnumber sources raised two edges ago.
  a_r5_req_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_o) <= $countones($past(src_i, 2)));

  // R7: unmapped reads return zero.
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bus_addr) >= (N_WORD + N_REQ)) |-> (bus_rdata == '0));

  // R9: a priority write is held from the following edge.
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              wr_d;

  always_comb wr_d = bus_wr && (32'(bus_addr) < N_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_d;
      addr_q <= bus_addr;
      data_q <= bus_wdata;
    end
  end

  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (levels[32'(addr_q)*WORD_W +: WORD_W] == data_q));

endmodule

bind irq_prio_router irq_router_checker #(
  .N_SRC  (N_SRC),
  .N_REQ  (N_REQ),
  .ADDR_W (ADDR_W),
  .N_WORD (N_WORD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .src_i     (src_i),
  .req_o     (req_o),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .levels    (lvl_flat),
  .hit       (hit_flat)
);

// File: tb/test_irq_prio_router.sv
`timescale 1ns/1ps
module test_irq_prio_router;

  logic        clk;
  logic        rst_n;
  logic [15:0] src_i;
  logic [11:0] req_o;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  irq_prio_router i_irq_prio_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .req_o     (req_o),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_total = 0;
  int n_bad   = 0;
  bit done    = 0;

  // Scoreboard item: either a request-output check or a register read.
  typedef struct {
    bit          is_read;
    logic [4:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;

  // Bench model of the priority words and of the applied sources.
  logic [15:0] m_prio [4];
  logic [15:0] m_src;

  function automatic logic [3:0] m_lvl(int i);
    return m_prio[i/4][4*(i%4) +: 4];
  endfunction

  function automatic logic [15:0] m_req();
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      if (m_src[i] && m_lvl(i) < 4'd12) r[m_lvl(i)] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [15:0] m_stat(int k);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      if (m_src[i] && m_lvl(i) == 4'(k)) r[i] = 1'b1;
    end
    return r;
  endfunction

  // Monitor: pops queued expectations and compares against the ports.
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = it.is_read ? bus_rdata : {4'b0000, req_o};
        n_total++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual=0x%04h expected=0x%04h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic fire();
    #1;
    ->sample_ev;
    #1;
  endtask

  task automatic expect_req(logic [15:0] exp, string tag);
    item_t it;
    it.is_read = 1'b0; it.addr = '0; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    fire();
  endtask

  task automatic expect_read(logic [4:0] a, logic [15:0] exp, string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_read = 1'b1; it.addr = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    fire();
  endtask

  task automatic bus_write(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    if (a < 5'd4) m_prio[a[1:0]] = d;
  endtask

  // Apply sources and wait until they have crossed the synchroniser.
  task automatic drive_src(logic [15:0] v);
    @(negedge clk);
    src_i = v;
    m_src = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_prio_words(string tag);
    for (int w = 0; w < 4; w++) expect_read(5'(w), m_prio[w], tag);
  endtask

  initial begin
    rst_n = 1'b0; src_i = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    m_src = '0;
    m_prio[0] = 16'h3210; m_prio[1] = 16'h7654;
    m_prio[2] = 16'hBA98; m_prio[3] = 16'h0BBB;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset words and quiet outputs.
    expect_req(16'h0000, "R1 reset req");
    check_prio_words("R1 reset word");

    // R2 R3: reset routing, one source per word position.
    drive_src(16'h0020); expect_req(16'h0020, "R3 src5 to line5");
    drive_src(16'h0200); expect_req(16'h0200, "R2 src9 to line9");
    drive_src(16'h1000); expect_req(16'h0800, "R2 src12 to line11");
    drive_src(16'h8000); expect_req(16'h0001, "R2 src15 to line0");
    expect_read(5'd4, 16'h8000, "R6 status line0");

    // R8: a step shows after two edges, not one.
    drive_src(16'h0000);
    @(negedge clk); src_i = 16'h0008; m_src = 16'h0008;
    @(negedge clk); expect_req(16'h0000, "R8 after one edge");
    @(negedge clk); expect_req(16'h0008, "R8 after two edges");

    // R9 R4: new fields, src1 masked by 12.
    bus_write(5'd0, 16'h00C5);
    expect_read(5'd0, 16'h00C5, "R9 readback word0");
    drive_src(16'h0003);
    expect_req(16'h0020, "R4 src1 masked, src0 on line5");
    expect_read(5'd9, 16'h0001, "R6 status line5");
    expect_read(5'd16, 16'h0000, "R7 unmapped read");

    // R5: three sources sharing line5.
    bus_write(5'd1, 16'h7554);
    drive_src(16'h0061);
    expect_req(16'h0020, "R5 shared line5");
    expect_read(5'd9, 16'h0061, "R5 status shared");
    drive_src(16'h0040);
    expect_req(16'h0020, "R5 one source left");
    drive_src(16'h0000);
    expect_req(16'h0000, "R5 all dropped");

    // R4: masking values 12..15 on word2.
    bus_write(5'd2, 16'hFEDC);
    drive_src(16'h0F00);
    expect_req(16'h0000, "R4 values 12-15 mask");
    for (int k = 0; k < 12; k++) expect_read(5'(4 + k), 16'h0000, "R4 status clear");

    // R7: writes to status and unmapped addresses are ignored.
    drive_src(16'h0001);
    bus_write(5'd9, 16'hFFFF);
    bus_write(5'd20, 16'hFFFF);
    bus_write(5'd31, 16'h1234);
    check_prio_words("R7 words kept");
    expect_read(5'd9, 16'h0001, "R7 status unchanged");
    expect_read(5'd20, 16'h0000, "R7 unmapped still zero");
    expect_req(m_req(), "R7 routing kept");

    // R3 R6 R9: pseudo-random words and sources against the model.
    for (int n = 0; n < 60; n++) begin
      int unsigned w;
      int unsigned k;
      w = $urandom_range(0, 3);
      bus_write(5'(w), 16'($urandom));
      drive_src(16'($urandom));
      expect_req(m_req(), "R3 random routing");
      k = $urandom_range(0, 11);
      expect_read(5'(4 + k), m_stat(int'(k)), "R6 random status");
      expect_read(5'(w), m_prio[w], "R9 random readback");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

endmodule